// File: doc/BRIEF.md
# Descriptor-Chained Audio Playback DMA

This block is a bus-master engine that plays 16-bit audio out of system memory. Software builds a list of two-dword descriptors in memory. Each descriptor names a memory region and carries three flags: end of list, page marker and jump. Software writes the address of the first descriptor into the pointer register and sets the enable bit. The engine then fetches descriptors one after another. It reads each region through a request/acknowledge memory port and presents the region's contents as 16-bit samples on a valid/ready output.

The pointer register always shows the address of the next descriptor to be fetched. A descriptor with the jump flag set redirects the walk to a new address instead of moving data, so software can build a circular list. A region with the page flag set raises a status bit and the interrupt line when its last sample has been accepted. If a second page event arrives before software has read the status, the engine records an error and stops moving data until the status register is read. A region with the end-of-list flag set stops the engine.

Top module: `pcm_desc_dma`

## Requirements
- R1: Reset behaviour. After reset the command, status and pointer registers read zero, and `busy`, `irq`, `mem_req` and `smp_valid` are low.
- R2: Register map and readback. `reg_addr` selects the register: 0 is command, 1 is status, 2 is pointer. In the command register, bit 0 is enable and bit 3 is direction, and every other bit reads 0. The pointer register stores bits 31:2 of a write, and its bits 1:0 read 0. The status register is read-only, so a write to it has no effect.
- R3: Start condition. The engine leaves idle only when enable is 1 and direction is 0. With direction 1 it issues no memory request and stays not busy.
- R4: Descriptor fetch. Descriptor word 0 (the region base) is read at the pointer address and word 1 at pointer + 4. After the fetch, the pointer register reads the descriptor address + 8.
- R5: Sample stream. In word 1, bits 15:0 hold the byte count. The region is read one dword at a time from its dword-aligned base, at base, base+4 and so on. Each dword yields its low halfword first, then its high halfword. Exactly byte_count/2 samples (rounded down) are emitted, and a count below 2 emits none. Only the dwords needed are read.
- R6: Jump. In word 1, bit 29 is the jump flag. When it is set, no data moves and no other flag of that descriptor applies. The dword-aligned base becomes the pointer, and the next descriptor is fetched from there.
- R7: Page event. In word 1, bit 30 is the page flag. After the last sample of a region with this flag, status bit 0 becomes 1. It stays 1 until the status register is read. `irq` is high exactly while any status bit is 1.
- R8: Error pause. If a page event occurs while status bit 0 is still 1, status bit 1 becomes 1 and the engine issues neither memory requests nor samples. It stays this way until the status register is read. A status read returns the current bits, clears them and resumes the engine.
- R9: End of list. In word 1, bit 31 is the end-of-list flag. After a region with this flag, `busy` drops and no further memory request is made until enable is written 0 and then 1. The restart begins at the current pointer.
- R10: A pointer write while `busy` is high has no effect.
- R11: Handshake stability. While `mem_req` is high without `mem_ack`, `mem_req` and `mem_addr` hold. While `smp_valid` is high without `smp_ready`, `smp_valid` and `smp_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read of status clears it) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory byte address (dword aligned) |
| mem_ack | input | 1 | Memory acknowledge; `mem_rdata` valid in this cycle |
| mem_rdata | input | 32 | Memory read data |
| smp_valid | output | 1 | Sample valid |
| smp_ready | input | 1 | Sample accepted when high with `smp_valid` |
| smp_data | output | 16 | Audio sample |
| busy | output | 1 | Engine is walking a list (also while paused) |
| irq | output | 1 | Interrupt: any status bit set |

## Verification
The embedded assertions check the following on every cycle:
- the memory port and the sample port hold steady until their handshakes complete;
- an error pause stays silent until a status read;
- a status read empties the register;
- the page bit does not drop without a read;
- the pointer stays frozen against software while busy;
- a finished list stays finished.

Only the bench scenarios can show the rest:
- the order and values of the samples across a sweep of byte counts, memory latencies and back-pressure patterns;
- the exact addresses of descriptor and data fetches;
- how a jump redirects the walk;
- what the pointer reads back;
- the restart after end of list.

// File: rtl/pcm_dma_pkg.sv
package pcm_dma_pkg;

    localparam int DWORD_W   = 32;
    localparam int SMP_W     = 16;
    localparam int BCNT_W    = 16;
    localparam int REG_SEL_W = 2;

    localparam logic [REG_SEL_W-1:0] SEL_CMD  = 2'd0;
    localparam logic [REG_SEL_W-1:0] SEL_STAT = 2'd1;
    localparam logic [REG_SEL_W-1:0] SEL_PTR  = 2'd2;

    localparam int CMD_EN_BIT  = 0;
    localparam int CMD_DIR_BIT = 3;

    localparam int STAT_EOP = 0;
    localparam int STAT_ERR = 1;

    localparam int DF_EOT = 31;
    localparam int DF_EOP = 30;
    localparam int DF_JMP = 29;

    typedef struct packed {
        logic [DWORD_W-1:0] base;
        logic               eot;
        logic               eop;
        logic               jmp;
        logic [BCNT_W-1:0]  nbytes;
    } desc_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH0,
        ST_FETCH1,
        ST_DECODE,
        ST_RDREQ,
        ST_EMIT_LO,
        ST_EMIT_HI,
        ST_ENDREG,
        ST_PAUSE,
        ST_DONE
    } eng_state_t;

    function automatic logic [DWORD_W-1:0] pack_cmd(input logic en, input logic dir);
        logic [DWORD_W-1:0] r;
        r = '0;
        r[CMD_EN_BIT]  = en;
        r[CMD_DIR_BIT] = dir;
        return r;
    endfunction

endpackage

// File: rtl/pcm_dma_regs.sv
module pcm_dma_regs
    import pcm_dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [REG_SEL_W-1:0] reg_addr,
    input  logic [DWORD_W-1:0]   reg_wdata,
    output logic [DWORD_W-1:0]   reg_rdata,
    input  logic                 busy,
    input  logic                 ptr_upd,
    input  logic [ADDR_W-1:0]    ptr_upd_val,
    input  logic                 eop_evt,
    input  logic                 err_evt,
    output logic                 cmd_en,
    output logic                 cmd_dir,
    output logic [ADDR_W-1:0]    ptr_q,
    output logic [1:0]           stat_q,
    output logic                 stat_rd,
    output logic                 irq
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

    logic wr_cmd;
    logic wr_ptr;
    logic [1:0] stat_set;

    assign wr_cmd  = reg_wr && (reg_addr == SEL_CMD);
    assign wr_ptr  = reg_wr && (reg_addr == SEL_PTR) && !busy;
    assign stat_rd = reg_rd && (reg_addr == SEL_STAT);

    always_comb begin
        stat_set           = '0;
        stat_set[STAT_EOP] = eop_evt;
        stat_set[STAT_ERR] = err_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_en  <= 1'b0;
            cmd_dir <= 1'b0;
            ptr_q   <= '0;
            stat_q  <= '0;
        end else begin
            if (wr_cmd) begin
                cmd_en  <= reg_wdata[CMD_EN_BIT];
                cmd_dir <= reg_wdata[CMD_DIR_BIT];
            end
            if (ptr_upd) begin
                ptr_q <= ptr_upd_val;
            end else if (wr_ptr) begin
                ptr_q <= reg_wdata[ADDR_W-1:0] & ALIGN_MASK;
            end
            // an event in the same cycle as a read survives the clear
            stat_q <= (stat_rd ? 2'b00 : stat_q) | stat_set;
        end
    end

    always_comb begin
        case (reg_addr)
            SEL_CMD:  reg_rdata = pack_cmd(cmd_en, cmd_dir);
            SEL_STAT: reg_rdata = DWORD_W'(stat_q);
            SEL_PTR:  reg_rdata = DWORD_W'(ptr_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |stat_q;

    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !eop_evt && !err_evt) |=> (stat_q == 2'b00)); // R8

    AST_EOP_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_q[STAT_EOP] && !stat_rd) |=> stat_q[STAT_EOP]); // R7

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && !ptr_upd) |=> $stable(ptr_q)); // R10

endmodule

// File: rtl/pcm_dma_engine.sv
module pcm_dma_engine
    import pcm_dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_en,
    input  logic               cmd_dir,
    input  logic [ADDR_W-1:0]  ptr_q,
    input  logic               stat_eop,
    input  logic               stat_rd,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic [DWORD_W-1:0] mem_rdata,
    output logic               smp_valid,
    input  logic               smp_ready,
    output logic [SMP_W-1:0]   smp_data,
    output logic               busy,
    output logic               ptr_upd,
    output logic [ADDR_W-1:0]  ptr_upd_val,
    output logic               eop_evt,
    output logic               err_evt
);

    localparam int                HW_CNT_W   = BCNT_W - 1;
    localparam logic [ADDR_W-1:0] DW_STEP    = ADDR_W'(DWORD_W / 8);
    localparam logic [ADDR_W-1:0] DESC_STEP  = ADDR_W'(2 * DWORD_W / 8);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

    eng_state_t          state;
    logic [ADDR_W-1:0]   fetch_addr;
    logic [ADDR_W-1:0]   rd_addr;
    logic [DWORD_W-1:0]  word0;
    logic [DWORD_W-1:0]  dbuf;
    desc_t               desc;
    logic [HW_CNT_W-1:0] rem;

    logic                last_smp;
    logic [ADDR_W-1:0]   jump_tgt;
    logic [ADDR_W-1:0]   next_desc;
    logic [ADDR_W-1:0]   region_base;
    logic [HW_CNT_W-1:0] region_hw;
    logic                unused_bits;

    assign last_smp    = (rem == HW_CNT_W'(1));
    assign region_base = desc.base[ADDR_W-1:0] & ALIGN_MASK;
    assign jump_tgt    = region_base;
    assign next_desc   = fetch_addr + DESC_STEP;
    assign region_hw   = desc.nbytes[BCNT_W-1:1];
    assign unused_bits = desc.nbytes[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            fetch_addr <= '0;
            rd_addr    <= '0;
            word0      <= '0;
            dbuf       <= '0;
            desc       <= '0;
            rem        <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_en && !cmd_dir) begin
                        fetch_addr <= ptr_q;
                        state      <= ST_FETCH0;
                    end
                end
                ST_FETCH0: begin
                    if (mem_ack) begin
                        word0 <= mem_rdata;
                        state <= ST_FETCH1;
                    end
                end
                ST_FETCH1: begin
                    if (mem_ack) begin
                        desc.base   <= word0;
                        desc.eot    <= mem_rdata[DF_EOT];
                        desc.eop    <= mem_rdata[DF_EOP];
                        desc.jmp    <= mem_rdata[DF_JMP];
                        desc.nbytes <= mem_rdata[BCNT_W-1:0];
                        state       <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (desc.jmp) begin
                        fetch_addr <= jump_tgt;
                        state      <= ST_FETCH0;
                    end else begin
                        fetch_addr <= next_desc;
                        rd_addr    <= region_base;
                        rem        <= region_hw;
                        state      <= (region_hw == '0) ? ST_ENDREG : ST_RDREQ;
                    end
                end
                ST_RDREQ: begin
                    if (mem_ack) begin
                        dbuf  <= mem_rdata;
                        state <= ST_EMIT_LO;
                    end
                end
                ST_EMIT_LO: begin
                    if (smp_ready) begin
                        rem   <= rem - HW_CNT_W'(1);
                        state <= last_smp ? ST_ENDREG : ST_EMIT_HI;
                    end
                end
                ST_EMIT_HI: begin
                    if (smp_ready) begin
                        rem     <= rem - HW_CNT_W'(1);
                        rd_addr <= rd_addr + DW_STEP;
                        state   <= last_smp ? ST_ENDREG : ST_RDREQ;
                    end
                end
                ST_ENDREG: begin
                    if (err_evt)       state <= ST_PAUSE;
                    else if (desc.eot) state <= ST_DONE;
                    else               state <= ST_FETCH0;
                end
                ST_PAUSE: begin
                    if (!cmd_en)       state <= ST_IDLE;
                    else if (stat_rd)  state <= desc.eot ? ST_DONE : ST_FETCH0;
                end
                ST_DONE: begin
                    if (!cmd_en) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = (state == ST_FETCH0) || (state == ST_FETCH1) || (state == ST_RDREQ);
        case (state)
            ST_FETCH0: mem_addr = fetch_addr;
            ST_FETCH1: mem_addr = fetch_addr + DW_STEP;
            default:   mem_addr = rd_addr;
        endcase
        smp_valid   = (state == ST_EMIT_LO) || (state == ST_EMIT_HI);
        smp_data    = (state == ST_EMIT_HI) ? dbuf[DWORD_W-1:SMP_W] : dbuf[SMP_W-1:0];
        busy        = (state != ST_IDLE) && (state != ST_DONE);
        ptr_upd     = (state == ST_DECODE);
        ptr_upd_val = desc.jmp ? jump_tgt : next_desc;
        eop_evt     = (state == ST_ENDREG) && desc.eop && !stat_eop;
        err_evt     = (state == ST_ENDREG) && desc.eop && stat_eop;
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R11

    AST_SMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data))); // R11

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAUSE && cmd_en && !stat_rd) |=>
            (state == ST_PAUSE && !mem_req && !smp_valid)); // R8

    AST_EOT_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && cmd_en) |=> (!busy && !mem_req)); // R9

endmodule

// File: rtl/pcm_desc_dma.sv
module pcm_desc_dma
    import pcm_dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [REG_SEL_W-1:0] reg_addr,
    input  logic [DWORD_W-1:0]   reg_wdata,
    output logic [DWORD_W-1:0]   reg_rdata,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic [DWORD_W-1:0]   mem_rdata,
    output logic                 smp_valid,
    input  logic                 smp_ready,
    output logic [SMP_W-1:0]     smp_data,
    output logic                 busy,
    output logic                 irq
);

    logic              cmd_en;
    logic              cmd_dir;
    logic [ADDR_W-1:0] ptr_q;
    logic [1:0]        stat_q;
    logic              stat_rd;
    logic              ptr_upd;
    logic [ADDR_W-1:0] ptr_upd_val;
    logic              eop_evt;
    logic              err_evt;

    pcm_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .busy        (busy),
        .ptr_upd     (ptr_upd),
        .ptr_upd_val (ptr_upd_val),
        .eop_evt     (eop_evt),
        .err_evt     (err_evt),
        .cmd_en      (cmd_en),
        .cmd_dir     (cmd_dir),
        .ptr_q       (ptr_q),
        .stat_q      (stat_q),
        .stat_rd     (stat_rd),
        .irq         (irq)
    );

    pcm_dma_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .cmd_en      (cmd_en),
        .cmd_dir     (cmd_dir),
        .ptr_q       (ptr_q),
        .stat_eop    (stat_q[STAT_EOP]),
        .stat_rd     (stat_rd),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .smp_valid   (smp_valid),
        .smp_ready   (smp_ready),
        .smp_data    (smp_data),
        .busy        (busy),
        .ptr_upd     (ptr_upd),
        .ptr_upd_val (ptr_upd_val),
        .eop_evt     (eop_evt),
        .err_evt     (err_evt)
    );

endmodule

// File: tb/pcm_desc_dma_tb.sv
`timescale 1ns/1ps
module pcm_desc_dma_tb;

    localparam int ADDR_W   = 32;
    localparam int MEM_DW   = 512;
    localparam int WDOG_MAX = 150000;

    localparam logic [31:0] F_EOT = 32'h8000_0000;
    localparam logic [31:0] F_EOP = 32'h4000_0000;
    localparam logic [31:0] F_JMP = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        smp_valid;
    logic        smp_ready = 1'b0;
    logic [15:0] smp_data;
    logic        busy;
    logic        irq;

    pcm_desc_dma #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .smp_data  (smp_data),
        .busy      (busy),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int lat = 0;
    int rdy_mode = 0;
    int rdy_cnt = 0;
    int wcnt = 0;
    int hold_err = 0;
    logic req_wait = 1'b0;
    logic [31:0] req_addr = '0;
    logic smp_wait = 1'b0;
    logic [15:0] smp_hold = '0;

    logic [31:0] mem [MEM_DW];
    logic [15:0] smp_q [$];
    logic [31:0] fetch_q [$];

    function automatic logic [15:0] exp_smp(input int byte_addr);
        return 16'((byte_addr >> 1) ^ 32'h5A00);
    endfunction

    function automatic logic [31:0] fq_at(input int idx);
        if (idx < fetch_q.size()) return fetch_q[idx];
        return 32'hDEAD_BEEF;
    endfunction

    function automatic logic [31:0] sq_at(input int idx);
        if (idx < smp_q.size()) return 32'(smp_q[idx]);
        return 32'hDEAD_BEEF;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG_MAX) begin
            nfail++;
            $display("FAIL watchdog (all requirements): actual cycle %0d expected run end before it", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    // memory model and sample sink, driven away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            mem_ack   = 1'b0;
            wcnt      = 0;
            smp_ready = 1'b0;
            req_wait  = 1'b0;
            smp_wait  = 1'b0;
        end else begin
            if (req_wait && (!mem_req || mem_addr != req_addr)) hold_err++;
            if (smp_wait && (!smp_valid || smp_data != smp_hold)) hold_err++;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wcnt >= lat) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem[mem_addr[10:2]];
                    fetch_q.push_back(mem_addr);
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
            req_wait = mem_req && !mem_ack;
            req_addr = mem_addr;
            smp_ready = (rdy_mode == 0) ? 1'b1 : ((rdy_cnt % 3) != 0);
            rdy_cnt++;
            if (smp_valid && smp_ready) smp_q.push_back(smp_data);
            smp_wait = smp_valid && !smp_ready;
            smp_hold = smp_data;
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_logs();
        smp_q.delete();
        fetch_q.delete();
    endtask

    // single-descriptor run: byte count n, base and timing vary with n
    task automatic run_sweep(input int n);
        logic [31:0] d;
        int base;
        int nsmp;
        base     = 32'h200 + 32'h20 * n;
        nsmp     = n >> 1;
        lat      = n % 3;
        rdy_mode = n % 2;
        mem[16]  = 32'(base);
        mem[17]  = F_EOT | F_EOP | 32'(n);
        clear_logs();
        reg_write(2'd2, 32'h40);
        reg_write(2'd0, 32'h1);
        wait_idle();
        chk("R5 sample count", 32'(smp_q.size()), 32'(nsmp));
        for (int k = 0; k < nsmp; k++)
            chk("R5 sample value", sq_at(k), 32'(exp_smp(base + 2 * k)));
        chk("R5 memory reads", 32'(fetch_q.size()), 32'(2 + (nsmp + 1) / 2));
        chk("R4 word0 address", fq_at(0), 32'h40);
        chk("R4 word1 address", fq_at(1), 32'h44);
        if (nsmp > 0) chk("R5 region address", fq_at(2), 32'(base));
        reg_read(2'd2, d);
        chk("R4 pointer advanced", d, 32'h48);
        chk("R7 irq raised", 32'(irq), 32'h1);
        reg_read(2'd1, d);
        chk("R7 status page bit", d, 32'h1);
        chk("R7 irq cleared", 32'(irq), 32'h0);
        chk("R9 not busy", 32'(busy), 32'h0);
        reg_write(2'd0, 32'h0);
    endtask

    initial begin
        logic [31:0] d;
        int nlog;
        for (int i = 0; i < MEM_DW; i++)
            mem[i] = {exp_smp(4 * i + 2), exp_smp(4 * i)};

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        reg_read(2'd0, d); chk("R1 command", d, 32'h0);
        reg_read(2'd1, d); chk("R1 status", d, 32'h0);
        reg_read(2'd2, d); chk("R1 pointer", d, 32'h0);
        chk("R1 outputs", {28'd0, busy, irq, mem_req, smp_valid}, 32'h0);

        // R2 and R3: readback masking, direction blocks start
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_read(2'd0, d); chk("R2 command reserved bits", d, 32'h9);
        repeat (20) @(negedge clk);
        chk("R3 no request with direction 1", 32'(fetch_q.size()), 32'h0);
        chk("R3 idle with direction 1", 32'(busy), 32'h0);
        reg_write(2'd0, 32'h0);
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_read(2'd2, d); chk("R2 pointer low bits", d, 32'hFFFF_FFFC);
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd1, d); chk("R2 status read-only", d, 32'h0);

        // R5/R4/R7 sweep over byte counts, latencies and back-pressure
        for (int n = 0; n < 14; n++) run_sweep(n);

        // R8/R10: second page event pauses until status read
        lat = 1; rdy_mode = 1;
        mem[32] = 32'h600; mem[33] = F_EOP | 32'd4;
        mem[34] = 32'h610; mem[35] = F_EOP | 32'd4;
        mem[36] = 32'h620; mem[37] = F_EOT | 32'd4;
        clear_logs();
        reg_write(2'd2, 32'h80);
        reg_write(2'd0, 32'h1);
        repeat (150) @(negedge clk);
        chk("R8 busy while paused", 32'(busy), 32'h1);
        chk("R8 samples before pause", 32'(smp_q.size()), 32'd4);
        chk("R8 no request while paused", 32'(mem_req), 32'h0);
        chk("R8 irq while paused", 32'(irq), 32'h1);
        nlog = fetch_q.size();
        reg_write(2'd2, 32'h3F0);
        reg_read(2'd2, d); chk("R10 pointer write ignored while busy", d, 32'h90);
        chk("R8 no fetch during pause", 32'(fetch_q.size()), 32'(nlog));
        reg_read(2'd1, d); chk("R8 status error and page", d, 32'h3);
        wait_idle();
        chk("R8 resumed sample count", 32'(smp_q.size()), 32'd6);
        chk("R8 resumed sample 0", sq_at(4), 32'(exp_smp(32'h620)));
        chk("R8 resumed sample 1", sq_at(5), 32'(exp_smp(32'h622)));
        reg_read(2'd1, d); chk("R8 status cleared by read", d, 32'h0);
        chk("R8 irq cleared", 32'(irq), 32'h0);
        reg_read(2'd2, d); chk("R4 pointer after list", d, 32'h98);
        reg_write(2'd0, 32'h0);

        // R6: jump descriptor redirects the walk
        lat = 0; rdy_mode = 0;
        mem[48] = 32'h100; mem[49] = F_JMP | F_EOT | F_EOP | 32'h10;
        mem[64] = 32'h300; mem[65] = F_EOT | 32'd6;
        mem[66] = 32'h340; mem[67] = F_EOT | F_EOP | 32'd4;
        clear_logs();
        reg_write(2'd2, 32'hC0);
        reg_write(2'd0, 32'h1);
        wait_idle();
        chk("R6 jump word0", fq_at(0), 32'hC0);
        chk("R6 jump word1", fq_at(1), 32'hC4);
        chk("R6 target word0", fq_at(2), 32'h100);
        chk("R6 target word1", fq_at(3), 32'h104);
        chk("R6 no data from jump", fq_at(4), 32'h300);
        chk("R6 sample count", 32'(smp_q.size()), 32'd3);
        for (int k = 0; k < 3; k++)
            chk("R6 sample value", sq_at(k), 32'(exp_smp(32'h300 + 2 * k)));
        reg_read(2'd2, d); chk("R6 pointer after jump", d, 32'h108);
        reg_read(2'd1, d); chk("R6 flags of jump ignored", d, 32'h0);

        // R9: stays stopped while enabled, restarts after re-enable
        nlog = fetch_q.size();
        repeat (30) @(negedge clk);
        chk("R9 no request after end", 32'(fetch_q.size()), 32'(nlog));
        chk("R9 busy low after end", 32'(busy), 32'h0);
        clear_logs();
        reg_write(2'd0, 32'h0);
        reg_write(2'd0, 32'h1);
        wait_idle();
        chk("R9 restart address", fq_at(0), 32'h108);
        chk("R9 restart samples", 32'(smp_q.size()), 32'd2);
        chk("R9 restart sample 0", sq_at(0), 32'(exp_smp(32'h340)));
        chk("R9 restart sample 1", sq_at(1), 32'(exp_smp(32'h342)));
        reg_read(2'd1, d); chk("R7 page after restart", d, 32'h1);
        reg_write(2'd0, 32'h0);

        chk("R11 handshake hold violations", 32'(hold_err), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule